// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies a signed multiplicand of `X_W` bits by a signed multiplier of `Y_W` bits and returns the full `X_W+Y_W`-bit two's complement product. It takes several cycles per operation. One working register holds the partial product, the multiplier bits that have not been consumed yet, and a trailing zero bit. On each cycle the two lowest bits of this register select one of three actions: add the aligned multiplicand, add its aligned negation, or add nothing. The register is then shifted right arithmetically by one place. After `Y_W` such steps, the product is the register without its lowest bit and without its guard bit.

Operands arrive on a valid/ready input channel. `in_ready` is high only while the block is idle, and an operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. The result leaves on a valid/ready output channel. `out_valid` stays high, with `product` unchanged, until `out_ready` is seen high on a clock edge. While a result is waiting, the input channel is stalled. This is how back-pressure reaches the producer. The working register and both addends carry one guard bit above the multiplicand field, so negating the most negative multiplicand does not overflow.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `product` is 0.
- R2: An operand pair is taken only on an edge where `in_valid` and `in_ready` are both 1. From that edge until the result has been handed off, `in_ready` is 0, and `in_valid` together with the operand inputs has no effect on the result.
- R3: `product` equals the signed product of `mcand` and `mplier`, both read as two's complement, given as an `X_W+Y_W`-bit two's complement value.
- R4: `out_valid` rises on exactly the `Y_W`-th rising clock edge after the edge that took the operands.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `product` does not change.
- R6: The product is correct when the multiplicand is the most negative value, including when both operands are the most negative value.
- R7: On the edge where `out_valid` and `out_ready` are both 1, `out_valid` falls and `in_ready` rises.
- R8: While the block is idle, `product` keeps the last result until a new operand pair is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block is idle and can take operands |
| mcand | input | X_W | Signed multiplicand |
| mplier | input | Y_W | Signed multiplier |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| product | output | X_W+Y_W | Signed product |

## Verification
An addend or step fault gives a wrong `product`. The fault becomes visible on the first cycle of `out_valid`, `Y_W` cycles after the operands were taken. Operand pairs whose low multiplier bits contain both 01 and 10 transitions, and pairs that use the most negative multiplicand, bring out sign and guard-bit faults. A fault in the iteration count or the state machine moves the rise of `out_valid` away from cycle `Y_W`, or makes `in_ready` misbehave. The reference model in the bench flags either case on the same cycle. A fault in the hold logic shows up as a change in `product` or `out_valid` while the consumer is stalled or while the block is idle.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } booth_state_e;
endpackage

// File: rtl/booth_addend_gen.sv
// Builds the two pre-aligned addends from the multiplicand: +m and -m,
// each sign-extended by one guard bit and shifted above the multiplier field.
module booth_addend_gen #(
  parameter int X_W = 8,
  parameter int Y_W = 8,
  localparam int REG_W = X_W + Y_W + 2
) (
  input  logic [X_W-1:0]   mcand,
  output logic [REG_W-1:0] add_pos,
  output logic [REG_W-1:0] add_neg
);
  logic [X_W:0] m_ext;
  logic [X_W:0] m_neg;

  always_comb begin
    m_ext   = {mcand[X_W-1], mcand};
    m_neg   = (~m_ext) + {{X_W{1'b0}}, 1'b1};
    add_pos = {m_ext, {(Y_W+1){1'b0}}};
    add_neg = {m_neg, {(Y_W+1){1'b0}}};
  end
endmodule

// File: rtl/booth_step.sv
// One recoding step: look at the two lowest bits, conditionally add,
// then shift right arithmetically. Carry out of the top bit is dropped.
module booth_step #(
  parameter int X_W = 8,
  parameter int Y_W = 8,
  localparam int REG_W = X_W + Y_W + 2
) (
  input  logic [REG_W-1:0] acc,
  input  logic [REG_W-1:0] add_pos,
  input  logic [REG_W-1:0] add_neg,
  output logic [REG_W-1:0] acc_next
);
  logic [REG_W-1:0] sum;

  always_comb begin
    unique case (acc[1:0])
      2'b01:   sum = acc + add_pos;
      2'b10:   sum = acc + add_neg;
      default: sum = acc;
    endcase
    acc_next = {sum[REG_W-1], sum[REG_W-1:1]};
  end
endmodule

// File: rtl/booth_ctrl.sv
// Three-state controller with an iteration counter.
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int Y_W = 8,
  localparam int CNT_W = $clog2(Y_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step_en
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(Y_W - 1);

  booth_state_e     state;
  logic [CNT_W-1:0] iter;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign load      = in_ready && in_valid;
  assign step_en   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          iter  <= '0;
        end
        ST_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST) state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int X_W = 8,
  parameter int Y_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [X_W-1:0]     mcand,
  input  logic [Y_W-1:0]     mplier,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [X_W+Y_W-1:0] product
);
  localparam int REG_W = X_W + Y_W + 2;

  logic             load;
  logic             step_en;
  logic [REG_W-1:0] acc;
  logic [REG_W-1:0] acc_next;
  logic [REG_W-1:0] add_pos;
  logic [REG_W-1:0] add_neg;
  logic [REG_W-1:0] pos_q;
  logic [REG_W-1:0] neg_q;

  booth_ctrl #(.Y_W(Y_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .step_en(step_en)
  );

  booth_addend_gen #(.X_W(X_W), .Y_W(Y_W)) u_addend (
    .mcand(mcand), .add_pos(add_pos), .add_neg(add_neg)
  );

  booth_step #(.X_W(X_W), .Y_W(Y_W)) u_step (
    .acc(acc), .add_pos(pos_q), .add_neg(neg_q), .acc_next(acc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      pos_q <= '0;
      neg_q <= '0;
    end else if (load) begin
      acc   <= {{(X_W+1){1'b0}}, mplier, 1'b0};
      pos_q <= add_pos;
      neg_q <= add_neg;
    end else if (step_en) begin
      acc <= acc_next;
    end
  end

  assign product = acc[REG_W-2:1];
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int X_W = 8,
  parameter int Y_W = 8,
  localparam int LW = $clog2(Y_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [X_W+Y_W-1:0] product
);
  logic          busy;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lat  <= '0;
    end else if (in_valid && in_ready) begin
      busy <= 1'b1;
      lat  <= '0;
    end else if (busy && !out_valid && lat < LW'(Y_W)) begin
      lat <= lat + 1'b1;
    end else if (out_valid && out_ready) begin
      busy <= 1'b0;
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == LW'(Y_W)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));
  p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .product(product)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
  localparam int X_W = 8;
  localparam int Y_W = 8;
  localparam int P_W = X_W + Y_W;
  localparam time CLK_PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           out_ready = 1'b1;
  logic [X_W-1:0] mcand = '0;
  logic [Y_W-1:0] mplier = '0;
  logic           in_ready;
  logic           out_valid;
  logic [P_W-1:0] product;

  int checks = 0;
  int errors = 0;

  booth_seq_mul #(.X_W(X_W), .Y_W(Y_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand(mcand), .mplier(mplier), .out_valid(out_valid),
    .out_ready(out_ready), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: 0 idle, 1 busy, 2 result waiting
  int             m_phase = 0;
  int             m_cycles = 0;
  logic [P_W-1:0] m_prod = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase  <= 0;
      m_cycles <= 0;
      m_prod   <= '0;
    end else if (m_phase == 0) begin
      if (in_valid) begin
        m_phase  <= 1;
        m_cycles <= 0;
        m_prod   <= P_W'(longint'($signed(mcand)) * longint'($signed(mplier)));
      end
    end else if (m_phase == 1) begin
      m_cycles <= m_cycles + 1;
      if (m_cycles + 1 == Y_W) m_phase <= 2;
    end else if (out_ready) begin
      m_phase <= 0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 in_ready", 64'(in_ready), 64'(m_phase == 0));
      check("R4 R7 out_valid", 64'(out_valid), 64'(m_phase == 2));
      if (m_phase == 2) check("R3 R5 product", 64'(product), 64'(m_prod));
      if (m_phase == 0) check("R8 idle product", 64'(product), 64'(m_prod));
    end
  end

  task automatic run_op(input logic [X_W-1:0] a, input logic [Y_W-1:0] b, input int stall);
    @(posedge clk); #1;
    mcand = a; mplier = b; in_valid = 1'b1;
    @(posedge clk); #1;
    // R2: keep offering other operands while busy; they must be ignored
    mcand = ~a; mplier = b + 8'd3;
    out_ready = (stall == 0);
    while (!out_valid) begin @(posedge clk); #1; end
    in_valid = 1'b0;
    for (int i = 0; i < stall; i++) begin @(posedge clk); #1; end
    out_ready = 1'b1;
    @(posedge clk); #1;
    // R7: result handed off, block idle again
    check("R7 in_ready after handoff", 64'(in_ready), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1 in_ready", 64'(in_ready), 64'd1);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 product", 64'(product), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    run_op(8'd7, 8'd9, 0);
    run_op(8'hFF, 8'd1, 0);
    run_op(8'd0, 8'h80, 0);
    run_op(8'h55, 8'hAA, 0);
    run_op(8'd127, 8'd127, 0);
    // R6: most negative multiplicand
    run_op(8'h80, 8'h80, 0);
    run_op(8'h80, 8'd127, 0);
    run_op(8'h80, 8'hFF, 0);
    run_op(8'd127, 8'h80, 0);
    // R5: back-pressure
    run_op(8'hC3, 8'h3C, 5);
    run_op(8'h80, 8'h81, 3);
    for (int k = 0; k < 40; k++) run_op(8'($urandom), 8'($urandom), k % 3);
    // R8: idle with in_valid low keeps result
    repeat (6) @(posedge clk);
    #1;
    check("R8 idle hold", 64'(product), 64'(m_prod));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule